// File: doc/BRIEF.md
# Recirculating Serial Shift Memory

This block is a small byte store kept as one long circulating shift register. Only one bit is reachable at any moment: the bit sitting at a fixed access point. Each enabled shift moves the whole store on by one bit, least significant bit of each byte first. Internal counters follow which byte, and which bit of that byte, is currently at the access point.

A random read or write is started with a request, a target byte number and a read/write flag. The store keeps turning until the least significant bit of the target byte reaches the access point. Over the next eight shifts the block either captures those bits into a parallel read register or replaces them with bits taken from the serial input. Rotation then continues until the byte holding the current execution address is back at the access point, and the block signals completion. A word-select strobe marks byte boundaries, so an external clock controller can pace the rotation through the shift enable.

Top module: `serial_shift_mem`

## Requirements
- R1: After a synchronous active-low reset, `port_byte` is 0, the store holds all zeros, `busy`, `done` and `rd_data` are 0, and `word_sel` is 1.
- R2: Each cycle with `shift_en` high advances the access point by one bit. After eight shifts `port_byte` moves to the next byte, and byte 63 is followed by byte 0. With `shift_en` low, the position and `ser_out` hold.
- R3: `word_sel` is high exactly while bit 0 (the least significant bit) of a byte is at the access point.
- R4: `ser_out` always shows the bit at the access point. Bytes that are not being written come back unchanged after a full turn of 512 shifts.
- R5: A request with `wr`=0 that is accepted while idle latches `addr`. When the target byte's bit 0 reaches the access point, the next eight shifts load `rd_data` bit 0 through bit 7 in that order. `rd_data` changes only during such a read.
- R6: A request with `wr`=1 replaces the target byte with the eight `ser_in` values sampled on its eight access shifts, with the first sample going to bit 0.
- R7: After the eight access shifts, rotation continues until bit 0 of byte `exec_addr` is at the access point. `done` is then high for one cycle and `busy` falls on the next cycle. When `exec_addr` equals the target, a full extra turn is made. If the position before the accepting edge is p (in bits), the target is A and the execution address is E, then `done` rises after d1+8+d2 shifts. Here d1 = ((8A-p-1) mod 512)+1 and d2 = (8E-8A-8) mod 512.
- R8: A request made while `busy` is high is ignored. The running access keeps its target, its direction and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | Shift enable: rotate the store one bit this cycle |
| ser_in | input | 1 | Serial write bit, sampled on write access shifts |
| ser_out | output | 1 | Bit currently at the access point |
| req | input | 1 | Start a random access (taken only when idle) |
| wr | input | 1 | 1 = write, 0 = read, sampled with `req` |
| addr | input | 6 | Target byte number |
| exec_addr | input | 6 | Byte to return to after the access |
| rd_data | output | 8 | Byte captured by the last read |
| word_sel | output | 1 | High while a byte's bit 0 is at the access point |
| busy | output | 1 | An access or its return rotation is in progress |
| done | output | 1 | One-cycle pulse: back at the execution byte |
| port_byte | output | 6 | Number of the byte at the access point |

## Verification
The hardest cases to reach from the ports are a second request that lands while an access is already running, and a return to the same byte that was just accessed, which forces a whole extra turn. The stimulus raises a request with a different target and the opposite direction a few cycles into selected accesses. It then checks that the completion cycle still matches the arithmetic distance formula and that no other byte was disturbed. Separate reads set the execution address equal to the target. Because every byte is first written with a computed pattern and then read back, any stray write or skipped capture shows up as a data mismatch.

// File: rtl/ssm_pkg.sv
// Package: shared types for the recirculating serial shift memory.
// Assumes: nothing beyond IEEE 1800-2017.
package ssm_pkg;

    // Access sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // no access pending
        ST_SEEK = 2'd1,  // rotating toward the target byte
        ST_XFER = 2'd2,  // the target byte is passing the access point
        ST_HOME = 2'd3   // rotating back to the execution byte
    } ssm_state_t;

endpackage

// File: rtl/ssm_ring.sv
// Module: ssm_ring
// The circulating store plus the counters that say which byte and bit sit
// at the single access point. The store rotates one bit per enabled cycle.
// The bit leaving the access point re-enters at the far end, or is replaced
// by wr_bit when wr_bit_en is high.
// Assumes: BITS >= 2, BYTES >= 2; the store is reset to all zeros.
module ssm_ring #(
    parameter int BYTES = 64,
    parameter int BITS  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic                       wr_bit_en,
    input  logic                       wr_bit,
    output logic                       port_bit,
    output logic [$clog2(BYTES)-1:0]   byte_pos,
    output logic [$clog2(BITS)-1:0]    bit_pos
);
    localparam int AW  = $clog2(BYTES);
    localparam int BW  = $clog2(BITS);
    localparam int TOT = BYTES * BITS;
    localparam bit POW2_BYTES = (BYTES == (1 << AW));

    logic [TOT-1:0] store;
    logic [AW-1:0]  byte_nxt;
    logic           last_bit;

    assign port_bit = store[0];
    assign last_bit = (bit_pos == BW'(BITS - 1));

    // Pick the byte wrap logic: natural overflow for a power-of-two depth.
    generate
        if (POW2_BYTES) begin : g_wrap_pow2
            assign byte_nxt = byte_pos + 1'b1;
        end else begin : g_wrap_cmp
            assign byte_nxt = (byte_pos == AW'(BYTES - 1)) ? '0 : byte_pos + 1'b1;
        end
    endgenerate

    // Rotate the store by one bit, inserting either the recirculated or the written bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (shift_en) begin
            store <= {(wr_bit_en ? wr_bit : store[0]), store[TOT-1:1]};
        end
    end

    // Follow the position of the access point within the rotating store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_pos  <= '0;
            byte_pos <= '0;
        end else if (shift_en) begin
            if (last_bit) begin
                bit_pos  <= '0;
                byte_pos <= byte_nxt;
            end else begin
                bit_pos  <= bit_pos + 1'b1;
            end
        end
    end

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && last_bit && byte_pos == AW'(BYTES - 1)) |=> (byte_pos == '0 && bit_pos == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(byte_pos) && $stable(bit_pos) && $stable(port_bit)));

    p_recirc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !wr_bit_en) |=> (store[TOT-1] == $past(port_bit)));

    p_write_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && wr_bit_en) |=> (store[TOT-1] == $past(wr_bit)));

endmodule

// File: rtl/ssm_seq.sv
// Module: ssm_seq
// Access sequencer. It accepts a request only when idle, waits for the
// target byte's bit 0 at the access point, and spans the eight access shifts.
// It then waits for the execution byte's bit 0 and flags done in that cycle.
// Assumes: exec_addr is held stable while busy; position inputs come from ssm_ring.
module ssm_seq
    import ssm_pkg::*;
#(
    parameter int BYTES = 64,
    parameter int BITS  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic                       req,
    input  logic                       wr,
    input  logic [$clog2(BYTES)-1:0]   addr,
    input  logic [$clog2(BYTES)-1:0]   exec_addr,
    input  logic [$clog2(BYTES)-1:0]   byte_pos,
    input  logic [$clog2(BITS)-1:0]    bit_pos,
    output logic                       busy,
    output logic                       done,
    output logic                       xfer_bit,
    output logic                       xfer_wr
);
    localparam int AW = $clog2(BYTES);
    localparam int BW = $clog2(BITS);

    ssm_state_t    st;
    logic [AW-1:0] tgt;
    logic          wr_q;
    logic          at_tgt;
    logic          at_home;

    assign at_tgt   = (bit_pos == '0) && (byte_pos == tgt);
    assign at_home  = (bit_pos == '0) && (byte_pos == exec_addr);
    assign xfer_bit = (st == ST_XFER) || ((st == ST_SEEK) && at_tgt);
    assign xfer_wr  = wr_q;
    assign done     = (st == ST_HOME) && at_home;
    assign busy     = (st != ST_IDLE);

    // Advance the access sequence and latch the request fields while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            tgt  <= '0;
            wr_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req) begin
                        st   <= ST_SEEK;
                        tgt  <= addr;
                        wr_q <= wr;
                    end
                end
                ST_SEEK, ST_XFER: begin
                    if (xfer_bit && shift_en) begin
                        st <= (bit_pos == BW'(BITS - 1)) ? ST_HOME : ST_XFER;
                    end
                end
                ST_HOME: begin
                    if (at_home) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> ($stable(tgt) && $stable(wr_q)));

    p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_xfer_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER) |-> (byte_pos == tgt));

endmodule

// File: rtl/ssm_rdcap.sv
// Module: ssm_rdcap
// Parallel read register. On each enabled capture shift, the bit at the access
// point is stored into the bit slot selected by bit_idx.
// Assumes: cap_en is high only on read access shifts.
module ssm_rdcap #(
    parameter int BITS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_en,
    input  logic [$clog2(BITS)-1:0]  bit_idx,
    input  logic                     bit_in,
    output logic [BITS-1:0]          rd_data
);
    localparam int BW = $clog2(BITS);

    // One enabled flop per data bit.
    generate
        for (genvar i = 0; i < BITS; i++) begin : g_cap
            // Load this bit when its slot passes during a read.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rd_data[i] <= 1'b0;
                end else if (cap_en && bit_idx == BW'(i)) begin
                    rd_data[i] <= bit_in;
                end
            end
        end
    endgenerate

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (rd_data[$past(bit_idx)] == $past(bit_in)));

endmodule

// File: rtl/serial_shift_mem.sv
// Module: serial_shift_mem (top)
// Bit-serial byte store that circulates past a single access point. It serves
// one random read or write at a time, then turns the store back to the
// execution byte.
// Assumes: shift_en comes from an external pacing controller; exec_addr is
// stable during an access.
module serial_shift_mem #(
    parameter int BYTES = 64,
    parameter int BITS  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic                       ser_in,
    output logic                       ser_out,
    input  logic                       req,
    input  logic                       wr,
    input  logic [$clog2(BYTES)-1:0]   addr,
    input  logic [$clog2(BYTES)-1:0]   exec_addr,
    output logic [BITS-1:0]            rd_data,
    output logic                       word_sel,
    output logic                       busy,
    output logic                       done,
    output logic [$clog2(BYTES)-1:0]   port_byte
);
    localparam int AW = $clog2(BYTES);
    localparam int BW = $clog2(BITS);

    logic          port_bit;
    logic [BW-1:0] bit_pos;
    logic [AW-1:0] byte_pos;
    logic          xfer_bit;
    logic          xfer_wr;
    logic          cap_en;

    assign ser_out   = port_bit;
    assign port_byte = byte_pos;
    assign word_sel  = (bit_pos == '0);
    assign cap_en    = xfer_bit && !xfer_wr && shift_en;

    ssm_ring #(.BYTES(BYTES), .BITS(BITS)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .wr_bit_en (xfer_bit && xfer_wr),
        .wr_bit    (ser_in),
        .port_bit  (port_bit),
        .byte_pos  (byte_pos),
        .bit_pos   (bit_pos)
    );

    ssm_seq #(.BYTES(BYTES), .BITS(BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .req       (req),
        .wr        (wr),
        .addr      (addr),
        .exec_addr (exec_addr),
        .byte_pos  (byte_pos),
        .bit_pos   (bit_pos),
        .busy      (busy),
        .done      (done),
        .xfer_bit  (xfer_bit),
        .xfer_wr   (xfer_wr)
    );

    ssm_rdcap #(.BITS(BITS)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .bit_idx (bit_pos),
        .bit_in  (port_bit),
        .rd_data (rd_data)
    );

    p_word_sel_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_sel && shift_en) |=> !word_sel);

    p_done_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (word_sel && port_byte == exec_addr));

    p_rd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != $past(rd_data)) |-> $past(busy));

endmodule

// File: tb/serial_shift_mem_bench.sv
// Bench: writes every byte with a computed pattern, sweeps a full turn,
// then reads every byte back while checking completion timing arithmetically.
module serial_shift_mem_bench;
    localparam int NB  = 64;
    localparam int NT  = NB * 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_en = 1'b0;
    logic       ser_in;
    logic       ser_out;
    logic       req = 1'b0;
    logic       wr = 1'b0;
    logic [5:0] addr = '0;
    logic [5:0] exec_addr = '0;
    logic [7:0] rd_data;
    logic       word_sel;
    logic       busy;
    logic       done;
    logic [5:0] port_byte;

    logic [8:0] bpos;
    logic [7:0] wdata = '0;
    logic [7:0] mem [NB];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    serial_shift_mem u_serial_shift_mem (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
        .ser_out(ser_out), .req(req), .wr(wr), .addr(addr),
        .exec_addr(exec_addr), .rd_data(rd_data), .word_sel(word_sel),
        .busy(busy), .done(done), .port_byte(port_byte)
    );

    // Independent bit position of the access point, counted from reset.
    always @(posedge clk) begin
        if (!rst_n) bpos <= '0;
        else if (shift_en) bpos <= bpos + 9'd1;
    end

    assign ser_in = wdata[bpos[2:0]];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One access; the shift count to done is predicted from the R7 formula.
    task automatic do_op(input int a, input int e, input bit w, input int d, input bit poke);
        int p, d1, d2, expn, n;
        @(negedge clk);
        wdata = 8'(d); addr = 6'(a); exec_addr = 6'(e); wr = w; req = 1'b1;
        p    = int'(bpos);
        d1   = ((((a * 8) - p - 1) % NT) + NT) % NT + 1;
        d2   = ((((e * 8) - (a * 8) - 8) % NT) + NT) % NT;
        expn = d1 + 8 + d2;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) req = 1'b0;
            if (poke && n == 3) begin
                req = 1'b1; addr = 6'((a + 9) % NB); wr = !w;   // R8 stray request
            end
            if (poke && n == 4) req = 1'b0;
            if (done || n > 1500) break;
        end
        chk(n == expn, w ? "R7 write done timing" : "R7 read done timing", n, expn);
        chk(port_byte == 6'(e), "R7 home byte", int'(port_byte), e);
        @(negedge clk);
        chk(!busy && !done, "R7 busy falls after done", int'(busy), 0);
        if (w) mem[a] = 8'(d);
        else chk(rd_data == mem[a], poke ? "R8 read under stray req" : "R5 read data",
                 int'(rd_data), int'(mem[a]));
    endtask

    initial begin
        int errs;
        for (int i = 0; i < NB; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(port_byte == 6'd0, "R1 port_byte", int'(port_byte), 0);
        chk(!busy && !done, "R1 busy/done", int'(busy) + int'(done), 0);
        chk(rd_data == 8'h00, "R1 rd_data", int'(rd_data), 0);
        chk(word_sel == 1'b1, "R1 word_sel", int'(word_sel), 1);
        // R2: no movement without shift_en
        repeat (5) @(negedge clk);
        chk(port_byte == 6'd0 && word_sel, "R2 hold without shift", int'(port_byte), 0);
        shift_en = 1'b1;
        repeat (13) @(negedge clk);
        chk(port_byte == 6'd1, "R2 byte after 13 shifts", int'(port_byte), 1);
        chk(word_sel == 1'b0, "R3 mid-byte word_sel", int'(word_sel), 0);
        repeat (3) @(negedge clk);
        chk(port_byte == 6'd2 && word_sel, "R3 boundary after 16 shifts", int'(port_byte), 2);
        // R1: store cleared by reset
        do_op(5, 9, 1'b0, 0, 1'b0);
        // R6: write every byte
        for (int a = 0; a < NB; a++) do_op(a, (a + 1) % NB, 1'b1, (a * 29 + 71) & 255, a[0]);
        // R4/R3/R2: one full turn against the model
        errs = 0;
        for (int k = 0; k < NT; k++) begin
            @(negedge clk);
            if (ser_out !== mem[bpos[8:3]][bpos[2:0]]) errs++;
            if (word_sel !== (bpos[2:0] == 3'd0)) errs++;
            if (port_byte !== bpos[8:3]) errs++;
        end
        chk(errs == 0, "R4 recirculation sweep", errs, 0);
        // R2: hold mid-turn, ser_out frozen
        shift_en = 1'b0;
        begin
            logic hold_bit;
            logic [5:0] hold_byte;
            hold_bit = ser_out; hold_byte = port_byte;
            repeat (4) @(negedge clk);
            chk(ser_out == hold_bit && port_byte == hold_byte, "R2 hold mid-turn",
                int'(port_byte), int'(hold_byte));
        end
        shift_en = 1'b1;
        // R5/R6: read every byte back, some with a stray request
        for (int a = 0; a < NB; a++) do_op(a, (a * 5 + 3) % NB, 1'b0, 0, (a % 3) == 0);
        // R7: execution byte equal to target forces a full extra turn
        do_op(17, 17, 1'b0, 0, 1'b0);
        do_op(63, 63, 1'b1, 8'hA5, 1'b0);
        do_op(63, 0, 1'b0, 0, 1'b1);
        do_op(0, 63, 1'b0, 0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule